// File: doc/BRIEF.md
# Two-Byte Accumulator Sequencer CPU

This block is a small 8-bit accumulator processor that drives a single byte-wide read/write memory. Every instruction occupies two consecutive memory bytes: an opcode byte followed by an address byte. The address byte either names the memory operand, names the store location, or supplies a signed branch offset.

Each instruction runs through seven fixed clock phases. The block latches the opcode and steps the program counter. It then latches the address byte and reads the operand from that address. Next it updates the accumulator and, for a store, writes it back. Last, it steps the program counter a second time. That second step is normally +1. For the branch opcode with a zero accumulator, it adds the address byte modulo 256 instead. Memory reads are combinational: the memory must present the byte at `memAddr` on `memRdata` within the same cycle.

Top module: `seq_cpu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter becomes 0, the accumulator 0 and the sequencer phase 1; `memAddr` then reads 0 and `memWe` reads 0.
- R2: In phase 1 `memAddr` is the program counter and the byte read is kept as the opcode; in phase 2 the program counter increases by one; in phase 3 `memAddr` is the incremented counter and the byte read is kept as the address byte.
- R3: In phases 4, 5 and 6 `memAddr` equals the address byte; the byte read in phase 4 is the operand.
- R4: Opcode value 1 inverts the accumulator, 2 ANDs it with the operand, 3 ORs it with the operand, 4 adds the operand modulo 256, 5 loads the operand; the new value is visible from the end of phase 5.
- R5: Opcodes 0, 6 and 7 leave the accumulator unchanged, although an operand read still occurs.
- R6: `memWe` is high only in phase 6 of opcode 6, with `memAddr` equal to the address byte and `memWdata` equal to the accumulator.
- R7: In phase 7 the program counter increases by one when no branch is taken.
- R8: Opcode 7 with a zero accumulator adds the address byte to the program counter in phase 7 (8-bit wrap), so the offset counts from the address-byte location; offset 0xFF makes the instruction repeat itself forever.
- R9: Opcode 7 with a non-zero accumulator behaves as a plain +1 step.
- R10: Only the low three bits of the opcode byte select the operation; the upper five bits are ignored.
- R11: Phases advance 1 to 7 and back to 1, so each instruction takes exactly seven clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 8 | Memory address |
| memWdata | output | 8 | Data written to memory |
| memRdata | input | 8 | Data read from memory (combinational) |
| memWe | output | 1 | Write strobe, one cycle wide |

## Verification
The program counter is touched twice per instruction, and the second touch is where the conditional branch and the ordinary +1 step meet. In the same phase 7, the zero test on the accumulator decides between them. The bench makes this contest sharp with a few instruction sequences. One branch has a non-zero accumulator. One branch follows a load of zero and must skip a store. The final branch has offset 0xFF and must keep re-fetching its own address. A behavioural reference model, stepped every clock, predicts the address, the write strobe and the write data. The contents of memory after the run settle whether the skipped store was really skipped.

// File: rtl/seq_cpu_pkg.sv
package seq_cpu_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [2:0] {
    PH_CODE  = 3'd0,
    PH_INC1  = 3'd1,
    PH_ADDR  = 3'd2,
    PH_FETCH = 3'd3,
    PH_EXEC  = 3'd4,
    PH_STORE = 3'd5,
    PH_STEP  = 3'd6
  } phase_e;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 3'd0,
    OP_NOT   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_ADD   = 3'd4,
    OP_LOAD  = 3'd5,
    OP_STORE = 3'd6,
    OP_BRZ   = 3'd7
  } opcode_e;

  typedef struct packed {
    logic loadCode;
    logic incPc;
    logic loadAddr;
    logic selAddrReg;
    logic loadOperand;
    logic loadAcc;
    logic writeMem;
    logic stepPc;
    logic takeBranch;
  } ctrl_t;

endpackage

// File: rtl/seq_cpu_alu.sv
module seq_cpu_alu
  import seq_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  opcode_e       opCode,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result
);

  always_comb begin
    unique case (opCode)
      OP_NOT:  result = ~accIn;
      OP_AND:  result = accIn & operand;
      OP_OR:   result = accIn | operand;
      OP_ADD:  result = accIn + operand;
      OP_LOAD: result = operand;
      default: result = accIn;
    endcase
  end

endmodule

// File: rtl/seq_cpu_ctrl.sv
module seq_cpu_ctrl
  import seq_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opCode,
  input  logic    accZero,
  output phase_e  phase,
  output ctrl_t   strobes
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CODE;
    end else if (phase == PH_STEP) begin
      phase <= PH_CODE;
    end else begin
      phase <= phase_e'(phase + 3'd1);
    end
  end

  always_comb begin
    strobes = '0;
    unique case (phase)
      PH_CODE:  strobes.loadCode = 1'b1;
      PH_INC1:  strobes.incPc    = 1'b1;
      PH_ADDR:  strobes.loadAddr = 1'b1;
      PH_FETCH: begin
        strobes.selAddrReg  = 1'b1;
        strobes.loadOperand = 1'b1;
      end
      PH_EXEC: begin
        strobes.selAddrReg = 1'b1;
        strobes.loadAcc    = (opCode inside {OP_NOT, OP_AND, OP_OR, OP_ADD, OP_LOAD});
      end
      PH_STORE: begin
        strobes.selAddrReg = 1'b1;
        strobes.writeMem   = (opCode == OP_STORE);
      end
      PH_STEP: begin
        strobes.stepPc     = 1'b1;
        strobes.takeBranch = (opCode == OP_BRZ) && accZero;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/seq_cpu_dpath.sv
module seq_cpu_dpath
  import seq_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         strobes,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output opcode_e       opCode,
  output logic          accZero,
  output logic [DW-1:0] pcVal,
  output logic [DW-1:0] adVal,
  output logic [DW-1:0] accVal
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [OPC_W-1:0] codeReg;
  logic [DW-1:0]    operandReg;
  logic [DW-1:0]    aluResult;
  logic [DW-1:0]    stepAmount;

  assign opCode     = opcode_e'(codeReg);
  assign accZero    = (accVal == '0);
  assign memAddr    = strobes.selAddrReg ? adVal : pcVal;
  assign memWdata   = accVal;
  assign stepAmount = strobes.takeBranch ? adVal : ONE;

  seq_cpu_alu #(.DW(DW)) alu (
    .opCode  (opCode),
    .accIn   (accVal),
    .operand (operandReg),
    .result  (aluResult)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcVal <= '0;
    end else if (strobes.incPc) begin
      pcVal <= pcVal + ONE;
    end else if (strobes.stepPc) begin
      pcVal <= pcVal + stepAmount;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accVal <= '0;
    end else if (strobes.loadAcc) begin
      accVal <= aluResult;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeReg    <= '0;
      adVal      <= '0;
      operandReg <= '0;
    end else begin
      if (strobes.loadCode)    codeReg    <= memRdata[OPC_W-1:0];
      if (strobes.loadAddr)    adVal      <= memRdata;
      if (strobes.loadOperand) operandReg <= memRdata;
    end
  end

endmodule

// File: rtl/seq_cpu.sv
module seq_cpu
  import seq_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic          memWe
);

  ctrl_t         strobes;
  phase_e        phase;
  opcode_e       opCode;
  logic          accZero;
  logic [DW-1:0] pcVal;
  logic [DW-1:0] adVal;
  logic [DW-1:0] accVal;

  assign memWe = strobes.writeMem;

  seq_cpu_ctrl ctrl (
    .clk     (clk),
    .rst     (rst),
    .opCode  (opCode),
    .accZero (accZero),
    .phase   (phase),
    .strobes (strobes)
  );

  seq_cpu_dpath #(.DW(DW)) dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opCode   (opCode),
    .accZero  (accZero),
    .pcVal    (pcVal),
    .adVal    (adVal),
    .accVal   (accVal)
  );

endmodule

// File: rtl/seq_cpu_checker.sv
module seq_cpu_checker
  import seq_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input phase_e        phase,
  input opcode_e       opCode,
  input logic [DW-1:0] pcVal,
  input logic [DW-1:0] adVal,
  input logic [DW-1:0] accVal,
  input logic [DW-1:0] memAddr,
  input logic          memWe
);

  a_r11_wrap: assert property (@(posedge clk) disable iff (rst)
    phase == PH_STEP |=> phase == PH_CODE);

  a_r11_advance: assert property (@(posedge clk) disable iff (rst)
    phase != PH_STEP |=> phase == phase_e'($past(phase) + 3'd1));

  a_r2_first_step: assert property (@(posedge clk) disable iff (rst)
    phase == PH_INC1 |=> pcVal == $past(pcVal) + DW'(1));

  a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_INC1 && phase != PH_STEP) |=> $stable(pcVal));

  a_r3_operand_addr: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |-> memAddr == adVal);

  a_r5_acc_kept: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && opCode inside {OP_NOP, OP_STORE, OP_BRZ}) |=> $stable(accVal));

  a_r5_acc_only_exec: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EXEC |=> $stable(accVal));

  a_r6_write_phase: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (phase == PH_STORE && opCode == OP_STORE && memAddr == adVal));

  a_r8_taken: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STEP && opCode == OP_BRZ && accVal == '0) |=>
      pcVal == $past(pcVal) + $past(adVal));

  a_r9_not_taken: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STEP && !(opCode == OP_BRZ && accVal == '0)) |=>
      pcVal == $past(pcVal) + DW'(1));

endmodule

bind seq_cpu seq_cpu_checker #(.DW(DW)) chk (
  .clk     (clk),
  .rst     (rst),
  .phase   (phase),
  .opCode  (opCode),
  .pcVal   (pcVal),
  .adVal   (adVal),
  .accVal  (accVal),
  .memAddr (memAddr),
  .memWe   (memWe)
);

// File: tb/seq_cpu_test.sv
module seq_cpu_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata;
  logic       memWe;

  logic [7:0] mem [256];

  int vectors = 0;
  int fails   = 0;
  bit running = 1'b0;
  bit done    = 1'b0;

  // reference model state
  int         mPh = 1;
  logic [7:0] mPc = 8'h00;
  logic [7:0] mCode = 8'h00;
  logic [7:0] mAd = 8'h00;
  logic [7:0] mOp = 8'h00;
  logic [7:0] mAcc = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRdata = mem[memAddr];

  seq_cpu uut (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .memWe    (memWe)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
  end

  always @(posedge clk) begin
    if (rst) begin
      mPh  <= 1;
      mPc  <= 8'h00;
      mAcc <= 8'h00;
    end else begin
      case (mPh)
        1: mCode <= mem[mPc];
        2: mPc   <= mPc + 8'd1;
        3: mAd   <= mem[mPc];
        4: mOp   <= mem[mAd];
        5: case (mCode[2:0])
             3'd1: mAcc <= ~mAcc;
             3'd2: mAcc <= mAcc & mOp;
             3'd3: mAcc <= mAcc | mOp;
             3'd4: mAcc <= mAcc + mOp;
             3'd5: mAcc <= mOp;
             default: mAcc <= mAcc;
           endcase
        7: mPc <= (mCode[2:0] == 3'd7 && mAcc == 8'h00) ? mPc + mAd : mPc + 8'd1;
        default: ;
      endcase
      mPh <= (mPh == 7) ? 1 : mPh + 1;
    end
  end

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic string phaseReq(input int ph);
    case (ph)
      1, 2, 3: return "R2";
      4, 5:    return "R3";
      6:       return "R6";
      default: return "R7";
    endcase
  endfunction

  // per-cycle comparison against the model (R11 ordering, R4/R5 via write data)
  always @(negedge clk) begin
    if (running && !rst) begin
      logic [7:0] expAddr;
      logic       expWe;
      expAddr = (mPh >= 4 && mPh <= 6) ? mAd : mPc;
      expWe   = (mPh == 6) && (mCode[2:0] == 3'd6);
      check8(phaseReq(mPh), "memAddr", memAddr, expAddr);
      check8("R6", "memWe", {7'd0, memWe}, {7'd0, expWe});
      if (expWe) check8("R4 R5", "memWdata", memWdata, mAcc);
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // program: opcode byte, address byte
    mem[8'h00] = 8'h05; mem[8'h01] = 8'h80; // load [80]
    mem[8'h02] = 8'h04; mem[8'h03] = 8'h81; // add [81]
    mem[8'h04] = 8'h06; mem[8'h05] = 8'h90; // store 90
    mem[8'h06] = 8'h01; mem[8'h07] = 8'h00; // invert
    mem[8'h08] = 8'h02; mem[8'h09] = 8'h82; // and [82]
    mem[8'h0A] = 8'h03; mem[8'h0B] = 8'h83; // or [83]
    mem[8'h0C] = 8'h06; mem[8'h0D] = 8'h91; // store 91
    mem[8'h0E] = 8'hF5; mem[8'h0F] = 8'h84; // load with upper bits set (R10)
    mem[8'h10] = 8'h06; mem[8'h11] = 8'h92; // store 92
    mem[8'h12] = 8'h07; mem[8'h13] = 8'h02; // branch, acc non-zero (R9)
    mem[8'h14] = 8'h00; mem[8'h15] = 8'h00; // nop
    mem[8'h16] = 8'h05; mem[8'h17] = 8'h85; // load zero
    mem[8'h18] = 8'h07; mem[8'h19] = 8'h03; // branch taken, skip one (R8)
    mem[8'h1A] = 8'h06; mem[8'h1B] = 8'h93; // skipped store
    mem[8'h1C] = 8'h06; mem[8'h1D] = 8'h94; // store zero
    mem[8'h1E] = 8'h07; mem[8'h1F] = 8'hFF; // self loop (R8)
    mem[8'h80] = 8'h3C; mem[8'h81] = 8'hD5;
    mem[8'h82] = 8'h7B; mem[8'h83] = 8'h81;
    mem[8'h84] = 8'h5A; mem[8'h85] = 8'h00;
    mem[8'h93] = 8'h77; mem[8'h94] = 8'h55;

    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check8("R1", "memAddr in reset", memAddr, 8'h00);
      check8("R1", "memWe in reset", {7'd0, memWe}, 8'h00);
    end
    rst = 1'b0;
    running = 1'b1;

    repeat (200) @(negedge clk);
    while (mPh != 1) @(negedge clk);
    check8("R8", "halt fetch address", memAddr, 8'h1E);
    repeat (7) @(negedge clk);
    check8("R8", "halt repeats", memAddr, 8'h1E);
    running = 1'b0;

    check8("R4", "add wraps (mem 90)", mem[8'h90], 8'h11);
    check8("R4", "not/and/or chain (mem 91)", mem[8'h91], 8'hEB);
    check8("R10", "upper opcode bits ignored (mem 92)", mem[8'h92], 8'h5A);
    check8("R8", "skipped store (mem 93)", mem[8'h93], 8'h77);
    check8("R8", "branch target store (mem 94)", mem[8'h94], 8'h00);
    check8("R5", "store leaves program intact", mem[8'h1F], 8'hFF);

    done = 1'b1;
    finishRun();
  end

endmodule